// File: doc/BRIEF.md
# Profile-Selected DDS Phase Accumulator

This block is the digital phase engine of a direct digital synthesizer. It holds eight stored profiles. Each profile pairs a 48-bit frequency tuning word with a 14-bit phase offset. A 48-bit accumulator adds the active tuning word on every system clock, so the tuning word value sets how often the accumulator overflows, and that rate sets the output frequency. The phase output is the top 14 accumulator bits with the active offset added. A registered carry pulse marks each wrap of the accumulator.

Profiles are loaded through a plain parallel write port and can be read back. A 3-bit select input names the wanted profile. The select and the stored contents act only when an update strobe is sampled. At that edge the tuning word and the offset of the chosen profile are copied together into the active set, so a retune can never pair one profile's frequency with another profile's offset. The sine lookup and all analog stages sit outside this block.

Top module: `dds_profile_core`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears the accumulator, the carry pulse, all eight stored profiles and the active tuning word and offset, so that profile 0 with a zero tuning word is in effect.
- R2: At every clock edge out of reset, the accumulator takes the value (accumulator + active tuning word) modulo 2^48.
- R3: `phase_o` equals accumulator bits [47:34] plus the active 14-bit offset, modulo 2^14, and follows the registers in the same cycle.
- R4: `carry_o` is high for exactly the one cycle after each clock edge at which the 48-bit addition passes full scale, and low otherwise.
- R5: With `wr_en` high at a clock edge, stored profile `wr_addr` (0 to 7) takes tuning word `wr_data[47:0]` and offset `wr_data[61:48]`.
- R6: `rd_data` shows stored profile `rd_addr` in the same layout as R5, and `rd_data[63:62]` always reads 0, whatever was written to `wr_data[63:62]`.
- R7: Without an update strobe, neither a write to a stored profile nor a change of `prof_sel` alters the active tuning word or offset. The phase keeps advancing with the values already in effect.
- R8: With `upd` high at a clock edge, the active tuning word and offset both load from stored profile `prof_sel`. The new offset shows on `phase_o` after that edge, and the new tuning word is added from the following edge onward.
- R9: When a write and an update occur at the same edge, the update takes the contents the stored profile held before that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Profile write enable |
| wr_addr | input | 3 | Profile index to write |
| wr_data | input | 64 | Offset in [61:48], tuning word in [47:0], [63:62] ignored |
| rd_addr | input | 3 | Profile index to read |
| rd_data | output | 64 | Stored contents of profile `rd_addr` |
| prof_sel | input | 3 | Profile to make active at the next update |
| upd | input | 1 | Update strobe |
| phase_o | output | 14 | Truncated phase plus offset |
| carry_o | output | 1 | One-cycle accumulator wrap pulse |

## Verification
The bench drives tuning words of half scale and all-ones. A carry generator that is late by a cycle, or that is taken from the wrong bit, then shows a pulse pattern offset from the expected one. An offset near full scale forces the 14-bit phase sum to wrap. A widened adder would leak a high bit instead. Writes and select changes issued without a strobe, and a write to the profile being selected at the same edge, test the update rules: a bypassed staging stage would retune early or pick up the freshly written word. Writes with the two top data bits set test that the unused field reads back as zero.

// File: rtl/dds_prof_pkg.sv
package dds_prof_pkg;

   localparam int unsigned DEF_ACC_W   = 48;
   localparam int unsigned DEF_PHASE_W = 14;
   localparam int unsigned DEF_N_PROF  = 8;
   localparam int unsigned DEF_REG_W   = 64;

   // Selects how the phase word leaves the block.
   typedef enum logic [0:0] {
      PH_COMB = 1'b0,   // sum of registered terms, no extra latency
      PH_REG  = 1'b1    // extra output register, one cycle later
   } phase_out_e;

endpackage

// File: rtl/dds_prof_bank.sv
module dds_prof_bank #(
   parameter int unsigned N_PROF  = 8,
   parameter int unsigned ACC_W   = 48,
   parameter int unsigned PHASE_W = 14,
   parameter int unsigned REG_W   = 64
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic                       wr_en,
   input  logic [$clog2(N_PROF)-1:0]  wr_addr,
   input  logic [REG_W-1:0]           wr_data,
   input  logic [$clog2(N_PROF)-1:0]  rd_addr,
   output logic [REG_W-1:0]           rd_data,
   input  logic [$clog2(N_PROF)-1:0]  lk_sel,
   output logic [ACC_W-1:0]           lk_ftw,
   output logic [PHASE_W-1:0]         lk_ofs
);
   localparam int unsigned SEL_W = $clog2(N_PROF);
   localparam int unsigned PAD_W = REG_W - ACC_W - PHASE_W;

   logic [ACC_W-1:0]   ftw_q [N_PROF];
   logic [PHASE_W-1:0] ofs_q [N_PROF];

   // one storage slot per profile
   for (genvar g = 0; g < N_PROF; g++) begin : g_slot
      logic hit;
      assign hit = wr_en && (wr_addr == SEL_W'(g));
      always_ff @(posedge clk) begin
         if (rst) begin
            ftw_q[g] <= '0;
            ofs_q[g] <= '0;
         end else if (hit) begin
            ftw_q[g] <= wr_data[ACC_W-1:0];
            ofs_q[g] <= wr_data[ACC_W +: PHASE_W];
         end
      end
   end

   // read-back port, unused top field forced to zero
   if (PAD_W > 0) begin : g_pad
      assign rd_data = {{PAD_W{1'b0}}, ofs_q[rd_addr], ftw_q[rd_addr]};
   end else begin : g_nopad
      assign rd_data = {ofs_q[rd_addr], ftw_q[rd_addr]};
   end

   // lookup port feeding the active set
   assign lk_ftw = ftw_q[lk_sel];
   assign lk_ofs = ofs_q[lk_sel];

endmodule

// File: rtl/dds_prof_active.sv
module dds_prof_active #(
   parameter int unsigned ACC_W   = 48,
   parameter int unsigned PHASE_W = 14
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               upd,
   input  logic [ACC_W-1:0]   lk_ftw,
   input  logic [PHASE_W-1:0] lk_ofs,
   output logic [ACC_W-1:0]   act_ftw,
   output logic [PHASE_W-1:0] act_ofs
);
   // both halves move on the same edge, never one without the other
   always_ff @(posedge clk) begin
      if (rst) begin
         act_ftw <= '0;
         act_ofs <= '0;
      end else if (upd) begin
         act_ftw <= lk_ftw;
         act_ofs <= lk_ofs;
      end
   end
endmodule

// File: rtl/dds_phase_acc.sv
module dds_phase_acc #(
   parameter int unsigned ACC_W = 48
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [ACC_W-1:0] step,
   output logic [ACC_W-1:0] acc_q,
   output logic             wrap_q
);
   logic [ACC_W:0] sum;

   assign sum = {1'b0, acc_q} + {1'b0, step};

   always_ff @(posedge clk) begin
      if (rst) begin
         acc_q  <= '0;
         wrap_q <= 1'b0;
      end else begin
         acc_q  <= sum[ACC_W-1:0];
         wrap_q <= sum[ACC_W];
      end
   end
endmodule

// File: rtl/dds_phase_map.sv
module dds_phase_map
   import dds_prof_pkg::*;
#(
   parameter int unsigned ACC_W    = 48,
   parameter int unsigned PHASE_W  = 14,
   parameter phase_out_e  OUT_MODE = PH_COMB
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [ACC_W-1:0]   acc,
   input  logic [PHASE_W-1:0] ofs,
   output logic [PHASE_W-1:0] phase
);
   logic [PHASE_W-1:0] raw;

   // modulo 2^PHASE_W by width truncation
   assign raw = acc[ACC_W-1 -: PHASE_W] + ofs;

   if (OUT_MODE == PH_REG) begin : g_reg
      logic [PHASE_W-1:0] ph_q;
      always_ff @(posedge clk) begin
         if (rst) ph_q <= '0;
         else     ph_q <= raw;
      end
      assign phase = ph_q;
   end else begin : g_comb
      assign phase = raw;
   end
endmodule

// File: rtl/dds_profile_core.sv
module dds_profile_core
   import dds_prof_pkg::*;
#(
   parameter int unsigned N_PROF   = DEF_N_PROF,
   parameter int unsigned ACC_W    = DEF_ACC_W,
   parameter int unsigned PHASE_W  = DEF_PHASE_W,
   parameter int unsigned REG_W    = DEF_REG_W,
   parameter phase_out_e  OUT_MODE = PH_COMB
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic                       wr_en,
   input  logic [$clog2(N_PROF)-1:0]  wr_addr,
   input  logic [REG_W-1:0]           wr_data,
   input  logic [$clog2(N_PROF)-1:0]  rd_addr,
   output logic [REG_W-1:0]           rd_data,
   input  logic [$clog2(N_PROF)-1:0]  prof_sel,
   input  logic                       upd,
   output logic [PHASE_W-1:0]         phase_o,
   output logic                       carry_o
);
   localparam int unsigned SEL_W = $clog2(N_PROF);

   // elaboration-time parameter checks
   if (PHASE_W > ACC_W) begin : g_bad_phase
      $error("phase width exceeds accumulator width");
   end
   if (ACC_W + PHASE_W > REG_W) begin : g_bad_reg
      $error("profile fields do not fit the register width");
   end
   if ((1 << SEL_W) != N_PROF || N_PROF < 2) begin : g_bad_nprof
      $error("profile count must be a power of two, at least 2");
   end

   logic [ACC_W-1:0]   lk_ftw;
   logic [PHASE_W-1:0] lk_ofs;
   logic [ACC_W-1:0]   act_ftw;
   logic [PHASE_W-1:0] act_ofs;
   logic [ACC_W-1:0]   acc_q;

   dds_prof_bank #(
      .N_PROF (N_PROF), .ACC_W (ACC_W), .PHASE_W (PHASE_W), .REG_W (REG_W)
   ) u_bank (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .rd_addr (rd_addr),
      .rd_data (rd_data),
      .lk_sel  (prof_sel),
      .lk_ftw  (lk_ftw),
      .lk_ofs  (lk_ofs)
   );

   dds_prof_active #(
      .ACC_W (ACC_W), .PHASE_W (PHASE_W)
   ) u_active (
      .clk     (clk),
      .rst     (rst),
      .upd     (upd),
      .lk_ftw  (lk_ftw),
      .lk_ofs  (lk_ofs),
      .act_ftw (act_ftw),
      .act_ofs (act_ofs)
   );

   dds_phase_acc #(
      .ACC_W (ACC_W)
   ) u_acc (
      .clk    (clk),
      .rst    (rst),
      .step   (act_ftw),
      .acc_q  (acc_q),
      .wrap_q (carry_o)
   );

   dds_phase_map #(
      .ACC_W (ACC_W), .PHASE_W (PHASE_W), .OUT_MODE (OUT_MODE)
   ) u_map (
      .clk   (clk),
      .rst   (rst),
      .acc   (acc_q),
      .ofs   (act_ofs),
      .phase (phase_o)
   );

endmodule

// File: rtl/dds_prof_chk.sv
module dds_prof_chk #(
   parameter int unsigned ACC_W   = 48,
   parameter int unsigned PHASE_W = 14
) (
   input logic               clk,
   input logic               rst,
   input logic               upd,
   input logic [ACC_W-1:0]   acc_q,
   input logic [ACC_W-1:0]   act_ftw,
   input logic [PHASE_W-1:0] act_ofs,
   input logic               carry_o
);
   // armed: the previous edge was a non-reset edge
   logic armed;
   logic prev_rst;
   always_ff @(posedge clk) begin
      armed    <= !rst;
      prev_rst <= rst;
   end

   // R1
   always @(posedge clk) begin
      if (prev_rst === 1'b1) begin
         reset_state_chk: assert (acc_q == '0 && act_ftw == '0 && act_ofs == '0 && !carry_o)
            else $error("state not cleared after reset");
      end
   end

   // R2
   acc_step_chk: assert property (@(posedge clk) disable iff (rst)
      armed |-> acc_q == ACC_W'($past(acc_q) + $past(act_ftw)));

   // R4
   carry_wrap_chk: assert property (@(posedge clk) disable iff (rst)
      armed |-> carry_o == (acc_q < $past(acc_q)));

   // R7
   active_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (armed && !$past(upd)) |-> ($stable(act_ftw) && $stable(act_ofs)));

endmodule

bind dds_profile_core dds_prof_chk #(
   .ACC_W (ACC_W), .PHASE_W (PHASE_W)
) u_chk (
   .clk     (clk),
   .rst     (rst),
   .upd     (upd),
   .acc_q   (acc_q),
   .act_ftw (act_ftw),
   .act_ofs (act_ofs),
   .carry_o (carry_o)
);

// File: tb/dds_profile_core_tb.sv
`timescale 1ns/1ps
module dds_profile_core_tb_top;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_addr = '0;
   logic [63:0] wr_data = '0;
   logic [2:0]  rd_addr = '0;
   logic [63:0] rd_data;
   logic [2:0]  prof_sel = '0;
   logic        upd = 1'b0;
   logic [13:0] phase_o;
   logic        carry_o;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   dds_profile_core dut_i (
      .clk (clk), .rst (rst), .wr_en (wr_en), .wr_addr (wr_addr),
      .wr_data (wr_data), .rd_addr (rd_addr), .rd_data (rd_data),
      .prof_sel (prof_sel), .upd (upd), .phase_o (phase_o), .carry_o (carry_o)
   );

   // reference model, built from the requirements
   logic [47:0] m_ftw [8];
   logic [13:0] m_ofs [8];
   logic [47:0] m_acc;
   logic [47:0] m_aftw;
   logic [13:0] m_aofs;
   logic        m_carry;

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   // one clock: model steps at the edge, outputs are compared at the falling edge
   task automatic tick(input string tag);
      logic [48:0] s;
      @(posedge clk);
      if (rst) begin
         for (int i = 0; i < 8; i++) begin m_ftw[i] = '0; m_ofs[i] = '0; end
         m_acc = '0; m_aftw = '0; m_aofs = '0; m_carry = 1'b0;
      end else begin
         s = {1'b0, m_acc} + {1'b0, m_aftw};
         m_acc = s[47:0];
         m_carry = s[48];
         if (upd) begin m_aftw = m_ftw[prof_sel]; m_aofs = m_ofs[prof_sel]; end
         if (wr_en) begin m_ftw[wr_addr] = wr_data[47:0]; m_ofs[wr_addr] = wr_data[61:48]; end
      end
      @(negedge clk);
      check({tag, " R2 R3 phase"}, 64'(phase_o), 64'(14'(m_acc[47:34] + m_aofs)));
      check({tag, " R4 carry"}, 64'(carry_o), 64'(m_carry));
   endtask

   task automatic write_prof(input logic [2:0] slot, input logic [47:0] f, input logic [13:0] o);
      wr_en = 1'b1; wr_addr = slot; wr_data = {2'b11, o, f};
      tick("R5 write");
      wr_en = 1'b0; wr_data = '0;
      rd_addr = slot;
      #1;
      check("R5 R6 readback", rd_data, {2'b00, m_ofs[slot], m_ftw[slot]});
   endtask

   typedef struct packed {
      logic [2:0]  slot;
      logic [47:0] ftw;
      logic [13:0] ofs;
      logic [7:0]  run;
   } vec_t;

   localparam vec_t VECS [6] = '{
      '{3'd1, 48'h0400_0000_0000, 14'h0000, 8'd8},
      '{3'd5, 48'h8000_0000_0000, 14'h3FFF, 8'd6},
      '{3'd7, 48'hFFFF_FFFF_FFFF, 14'h0064, 8'd5},
      '{3'd0, 48'h0000_0000_0001, 14'h2000, 8'd4},
      '{3'd3, 48'h1234_5678_9ABC, 14'h0155, 8'd10},
      '{3'd2, 48'h0000_0000_0000, 14'h0007, 8'd3}
   };

   initial begin : wdog
      #200000;
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin : main
      @(negedge clk);
      rst = 1'b1;
      tick("R1 reset");
      tick("R1 reset");
      rst = 1'b0;
      // R1: reset state at the ports
      check("R1 phase", 64'(phase_o), 64'd0);
      check("R1 carry", 64'(carry_o), 64'd0);
      for (int i = 0; i < 8; i++) begin
         rd_addr = 3'(i); #1;
         check("R1 bank cleared", rd_data, 64'd0);
      end
      tick("R1 idle");

      // table walk: load, select, run (R5 R6 R8 R2 R3 R4)
      for (int v = 0; v < 6; v++) begin
         write_prof(VECS[v].slot, VECS[v].ftw, VECS[v].ofs);
         prof_sel = VECS[v].slot; upd = 1'b1;
         tick("R8 update");
         upd = 1'b0;
         for (int k = 0; k < int'(VECS[v].run); k++) tick("walk");
      end

      // R7: write and select change without strobe keep the active profile
      prof_sel = 3'd3; upd = 1'b1; tick("R8 select 3"); upd = 1'b0;
      write_prof(3'd3, 48'h0800_0000_0000, 14'h1111);
      prof_sel = 3'd4;
      for (int k = 0; k < 4; k++) tick("R7 no strobe");
      check("R7 active offset kept", 64'(phase_o), 64'(14'(m_acc[47:34] + 14'h0155)));
      prof_sel = 3'd3; upd = 1'b1; tick("R8 retune"); upd = 1'b0;
      for (int k = 0; k < 3; k++) tick("R8 new ftw");

      // R9: write and update same profile at the same edge
      wr_en = 1'b1; wr_addr = 3'd6; wr_data = {2'b00, 14'h2AAA, 48'h4000_0000_0000};
      prof_sel = 3'd6; upd = 1'b1;
      tick("R9 collide");
      wr_en = 1'b0; upd = 1'b0;
      check("R9 old offset taken", 64'(phase_o), 64'(14'(m_acc[47:34])));
      tick("R9 old ftw");
      upd = 1'b1; tick("R9 reselect"); upd = 1'b0;
      for (int k = 0; k < 4; k++) tick("R9 new ftw");

      // R4: all-ones word wraps on nearly every edge
      write_prof(3'd4, 48'hFFFF_FFFF_FFFF, 14'h0000);
      prof_sel = 3'd4; upd = 1'b1; tick("R4 select"); upd = 1'b0;
      for (int k = 0; k < 6; k++) tick("R4 dense carry");

      // R1: reset mid-run
      rst = 1'b1; tick("R1 mid reset"); rst = 1'b0;
      check("R1 mid phase", 64'(phase_o), 64'd0);
      rd_addr = 3'd4; #1;
      check("R1 mid bank", rd_data, 64'd0);
      for (int k = 0; k < 3; k++) tick("R1 after reset");

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule